// File: doc/BRIEF.md
# Display Command List Executor

This block walks a stream of 32-bit words that a fetch unit pulls from a command list in memory, and turns them into writes on a write-only register bus. Each instruction is two words: the data word comes first and the command word second. The top byte of the command word is the opcode. The block handles four kinds of instruction itself: a single register write with per-byte enables, an indexed burst that writes any number of following words to one register, a no-op, and an interrupt request.

Wait and poll opcodes are passed on unchanged to a separate wait unit. The executor then stalls until that unit reports completion. An opcode the block does not know sets an error flag that stays set, and execution stops until reset. The block never reads from the register bus. Address translation and memory access belong to the fetch unit.

Top module: `dcl_exec`

## Requirements
- R1: After reset, `rb_valid`, `wt_valid`, `irq` and `err` are low, and `fd_ready` is high so that the first word can be taken.
- R2: Words are consumed in pairs. The data word comes first and the command word second. The opcode is command word bits 31:24.
- R3: Opcode 0x01 (single write) makes one bus write. `rb_addr` is command bits 19:0, `rb_be` is command bits 23:20 and `rb_data` is the data word.
- R4: `rb_be` bit n selects data byte n, so bit 0 covers bits 7:0 and bit 3 covers bits 31:24. A register bus that honours the enables leaves the unselected bytes at their old value. An all-zero enable changes nothing.
- R5: Opcode 0x09 (indexed write) takes a count N from the data word. It then issues N writes to the offset in command bits 19:0, with all four enables set, using the next N stream words in stream order. N = 0 issues no write.
- R6: When N is odd, the one padding word that follows the burst is consumed and not written. The next instruction starts right after it.
- R7: While `rb_valid` is high and `rb_ready` is low, `fd_ready` is low and the pending write holds its address, data and enables.
- R8: Opcode 0x00 (no-op) makes no bus write, and the next instruction follows straight after it.
- R9: Opcode 0x07 raises `irq` for exactly one cycle, the cycle after its command word is accepted.
- R10: Opcodes 0x02, 0x03, 0x04, 0x05, 0x06 and 0x0A raise `wt_valid`. The outputs `wt_op` (command bits 31:24), `wt_hi` (command bits 23:0) and `wt_lo` (the data word) hold steady until `wt_done`. No word is fetched and no write is made in the meantime, and execution resumes afterwards.
- R11: Any other opcode sets `err`, which stays high until reset. From then on `fd_ready`, `rb_valid` and `wt_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fd_valid | input | 1 | Fetch word available |
| fd_data | input | 32 | Fetch word |
| fd_ready | output | 1 | Executor takes the fetch word this cycle |
| rb_valid | output | 1 | Register write pending |
| rb_ready | input | 1 | Register bus accepts the write |
| rb_addr | output | 20 | Register offset |
| rb_data | output | 32 | Write data |
| rb_be | output | 4 | Byte enables, bit n for byte n |
| wt_valid | output | 1 | Wait request to the wait unit |
| wt_done | input | 1 | Wait unit finished |
| wt_op | output | 8 | Wait opcode |
| wt_lo | output | 32 | Wait data word |
| wt_hi | output | 24 | Wait command bits 23:0 |
| irq | output | 1 | One-cycle interrupt pulse |
| err | output | 1 | Sticky unknown-opcode error |

## Verification
A wrong burst counter or padding flag shows up quickly on the bus. The next instruction is read from the wrong word, so a data word lands at a wrong offset, or a padding word is written, on the very next write after the burst. Words pairing up out of step inverts data and command, and this shows up as a false error or a garbage write within two instructions. A stuck wait or a lost error shows up at once on `fd_ready`, which must be low for the whole wait and after an error.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 8;
  localparam int OP_LSB = 24;
  localparam int BE_W   = WORD_W / 8;
  localparam int BE_LSB = 20;
  localparam int OFS_W  = 20;
  localparam int ARG_W  = OP_LSB;

  localparam logic [OP_W-1:0] OPC_NOP   = 8'h00;
  localparam logic [OP_W-1:0] OPC_WRITE = 8'h01;
  localparam logic [OP_W-1:0] OPC_W_US  = 8'h02;
  localparam logic [OP_W-1:0] OPC_W_LN  = 8'h03;
  localparam logic [OP_W-1:0] OPC_W_VB  = 8'h04;
  localparam logic [OP_W-1:0] OPC_W_IN  = 8'h05;
  localparam logic [OP_W-1:0] OPC_W_OUT = 8'h06;
  localparam logic [OP_W-1:0] OPC_IRQ   = 8'h07;
  localparam logic [OP_W-1:0] OPC_INDEX = 8'h09;
  localparam logic [OP_W-1:0] OPC_POLL  = 8'h0A;

  typedef enum logic [2:0] {CL_NOP, CL_WR, CL_IDX, CL_IRQ, CL_WAIT, CL_BAD} cls_e;
  typedef enum logic [2:0] {ST_LO, ST_HI, ST_WR, ST_BURST, ST_PAD, ST_WAIT, ST_HALT} st_e;

  function automatic cls_e op_class(input logic [OP_W-1:0] op);
    case (op)
      OPC_NOP:   return CL_NOP;
      OPC_WRITE: return CL_WR;
      OPC_INDEX: return CL_IDX;
      OPC_IRQ:   return CL_IRQ;
      OPC_W_US, OPC_W_LN, OPC_W_VB,
      OPC_W_IN, OPC_W_OUT, OPC_POLL: return CL_WAIT;
      default:   return CL_BAD;
    endcase
  endfunction

  // an odd number of burst words leaves one padding word to skip
  function automatic logic burst_padded(input logic lsb);
    return lsb;
  endfunction

  function automatic logic [OFS_W-1:0] cmd_ofs(input logic [WORD_W-1:0] cmd);
    return cmd[OFS_W-1:0];
  endfunction

  function automatic logic [BE_W-1:0] cmd_be(input logic [WORD_W-1:0] cmd);
    return cmd[BE_LSB +: BE_W];
  endfunction
endpackage

// File: rtl/dcl_decode.sv
module dcl_decode
  import dcl_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [OP_W-1:0]  op,
  input  logic [CNT_W-1:0] count,
  output cls_e             cls,
  output logic             empty,
  output logic             odd
);
  always_comb begin
    cls   = op_class(op);
    empty = (count == '0);
    odd   = burst_padded(count[0]);
  end
endmodule

// File: rtl/dcl_burst_ctr.sv
module dcl_burst_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             odd_in,
  input  logic             step,
  output logic             last,
  output logic             odd
);
  logic [CNT_W-1:0] rem_q;
  logic             odd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      odd_q <= 1'b0;
    end else if (load) begin
      rem_q <= load_val;
      odd_q <= odd_in;
    end else if (step && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign last = (rem_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign odd  = odd_q;
endmodule

// File: rtl/dcl_exec.sv
module dcl_exec
  import dcl_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fd_valid,
  input  logic [WORD_W-1:0]    fd_data,
  output logic                 fd_ready,
  output logic                 rb_valid,
  input  logic                 rb_ready,
  output logic [OFS_W-1:0]     rb_addr,
  output logic [WORD_W-1:0]    rb_data,
  output logic [BE_W-1:0]      rb_be,
  output logic                 wt_valid,
  input  logic                 wt_done,
  output logic [OP_W-1:0]      wt_op,
  output logic [WORD_W-1:0]    wt_lo,
  output logic [ARG_W-1:0]     wt_hi,
  output logic                 irq,
  output logic                 err
);
  st_e               st_q, st_d;
  logic [WORD_W-1:0] lo_q, hi_q;
  logic              irq_q, err_q;

  cls_e dec_cls;
  logic dec_empty, dec_odd;
  logic ctr_last, ctr_odd;

  // named internal events
  logic fetch_hs, bus_hs;
  logic ev_hdr_take, ev_burst_beat, ev_burst_end;
  logic in_burst, in_single;

  assign fetch_hs      = fd_valid && fd_ready;
  assign bus_hs        = rb_valid && rb_ready;
  assign in_burst      = (st_q == ST_BURST);
  assign in_single     = (st_q == ST_WR);
  assign ev_hdr_take   = (st_q == ST_HI) && fetch_hs;
  assign ev_burst_beat = in_burst && bus_hs;
  assign ev_burst_end  = ev_burst_beat && ctr_last;

  dcl_decode #(.CNT_W(CNT_W)) u_dec (
    .op    (fd_data[OP_LSB +: OP_W]),
    .count (lo_q[CNT_W-1:0]),
    .cls   (dec_cls),
    .empty (dec_empty),
    .odd   (dec_odd)
  );

  dcl_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_hdr_take && dec_cls == CL_IDX),
    .load_val (lo_q[CNT_W-1:0]),
    .odd_in   (dec_odd),
    .step     (ev_burst_beat),
    .last     (ctr_last),
    .odd      (ctr_odd)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_LO:    if (fetch_hs) st_d = ST_HI;
      ST_HI: begin
        if (fetch_hs) begin
          case (dec_cls)
            CL_WR:   st_d = ST_WR;
            CL_IDX:  st_d = dec_empty ? ST_LO : ST_BURST;
            CL_WAIT: st_d = ST_WAIT;
            CL_BAD:  st_d = ST_HALT;
            default: st_d = ST_LO;
          endcase
        end
      end
      ST_WR:    if (bus_hs) st_d = ST_LO;
      ST_BURST: if (ev_burst_end) st_d = ctr_odd ? ST_PAD : ST_LO;
      ST_PAD:   if (fetch_hs) st_d = ST_LO;
      ST_WAIT:  if (wt_done) st_d = ST_LO;
      default:  st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_LO;
      lo_q  <= '0;
      hi_q  <= '0;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      if (st_q == ST_LO && fetch_hs) lo_q <= fd_data;
      if (ev_hdr_take) hi_q <= fd_data;
      irq_q <= ev_hdr_take && (dec_cls == CL_IRQ);
      err_q <= err_q || (ev_hdr_take && dec_cls == CL_BAD);
    end
  end

  always_comb begin
    case (st_q)
      ST_LO, ST_HI, ST_PAD: fd_ready = 1'b1;
      ST_BURST:             fd_ready = rb_ready;
      default:              fd_ready = 1'b0;
    endcase
  end

  assign rb_valid = in_single || (in_burst && fd_valid);
  assign rb_addr  = cmd_ofs(hi_q);
  assign rb_data  = in_burst ? fd_data : lo_q;
  assign rb_be    = in_burst ? {BE_W{1'b1}} : cmd_be(hi_q);

  assign wt_valid = (st_q == ST_WAIT);
  assign wt_op    = hi_q[OP_LSB +: OP_W];
  assign wt_hi    = hi_q[ARG_W-1:0];
  assign wt_lo    = lo_q;

  assign irq = irq_q;
  assign err = err_q;
endmodule

// File: rtl/dcl_exec_chk.sv
module dcl_exec_chk
  import dcl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fd_ready,
  input logic              rb_valid,
  input logic              rb_ready,
  input logic [OFS_W-1:0]  rb_addr,
  input logic [WORD_W-1:0] rb_data,
  input logic [BE_W-1:0]   rb_be,
  input logic              wt_valid,
  input logic              wt_done,
  input logic [OP_W-1:0]   wt_op,
  input logic              irq,
  input logic              err,
  input logic              in_burst,
  input logic              in_single
);
  AST_STALL_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid && !rb_ready |-> !fd_ready); // R7
  AST_SINGLE_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_single && rb_valid && !rb_ready |=> rb_valid && $stable(rb_addr) && $stable(rb_data) && $stable(rb_be)); // R7
  AST_BURST_FULL_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && rb_valid |-> rb_be == {BE_W{1'b1}}); // R5
  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
  AST_WAIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid |-> !rb_valid && !fd_ready); // R10
  AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid && !wt_done |=> wt_valid && $stable(wt_op)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R11
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !fd_ready && !rb_valid && !wt_valid); // R11
endmodule

bind dcl_exec dcl_exec_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fd_ready  (fd_ready),
  .rb_valid  (rb_valid),
  .rb_ready  (rb_ready),
  .rb_addr   (rb_addr),
  .rb_data   (rb_data),
  .rb_be     (rb_be),
  .wt_valid  (wt_valid),
  .wt_done   (wt_done),
  .wt_op     (wt_op),
  .irq       (irq),
  .err       (err),
  .in_burst  (in_burst),
  .in_single (in_single)
);

// File: tb/dcl_exec_bench.sv
module dcl_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fd_valid, fd_ready;
  logic [31:0] fd_data;
  logic        rb_valid, rb_ready;
  logic [19:0] rb_addr;
  logic [31:0] rb_data;
  logic [3:0]  rb_be;
  logic        wt_valid;
  logic        wt_done;
  logic [7:0]  wt_op;
  logic [31:0] wt_lo;
  logic [23:0] wt_hi;
  logic        irq, err;

  always #4 clk = ~clk;

  dcl_exec u_dcl_exec (
    .clk(clk), .rst_n(rst_n),
    .fd_valid(fd_valid), .fd_data(fd_data), .fd_ready(fd_ready),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_addr(rb_addr),
    .rb_data(rb_data), .rb_be(rb_be),
    .wt_valid(wt_valid), .wt_done(wt_done), .wt_op(wt_op),
    .wt_lo(wt_lo), .wt_hi(wt_hi), .irq(irq), .err(err)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // command stream source
  logic [31:0] str [0:511];
  int slen = 0;
  int sidx = 0;
  assign fd_valid = (sidx < slen);
  assign fd_data  = str[sidx[8:0]];
  always @(posedge clk) if (fd_valid && fd_ready) sidx <= sidx + 1;

  // register bus ready pattern
  bit bp_mode = 0;
  int cyc = 0;
  initial rb_ready = 1'b1;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rb_ready <= !bp_mode || (cyc % 3 != 2);
  end

  // wait unit responder
  int wcnt = 0;
  initial wt_done = 1'b0;
  always @(posedge clk) begin
    if (wt_valid && !wt_done) begin
      if (wcnt == 3) wt_done <= 1'b1;
      else wcnt <= wcnt + 1;
    end else begin
      wt_done <= 1'b0;
      wcnt <= 0;
    end
  end

  // monitors
  logic [19:0] wa [0:63];
  logic [31:0] wd [0:63];
  logic [3:0]  wb [0:63];
  logic [31:0] rmod [0:15];
  int nw = 0;
  int stall_bad = 0, hold_bad = 0, wait_bad = 0, irq_wide = 0, nirq = 0, nwait = 0;
  logic [7:0]  wop [0:7];
  logic [31:0] wlo [0:7];
  logic [23:0] whi [0:7];
  bit stall_prev = 0, irq_prev = 0, wt_prev = 0;
  logic [19:0] pa; logic [31:0] pd; logic [3:0] pb;

  initial for (int i = 0; i < 16; i++) rmod[i] = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rb_valid && rb_ready) begin
        wa[nw[5:0]] = rb_addr; wd[nw[5:0]] = rb_data; wb[nw[5:0]] = rb_be;
        nw++;
        for (int b = 0; b < 4; b++)
          if (rb_be[b]) rmod[rb_addr[3:0]][8*b +: 8] = rb_data[8*b +: 8];
      end
      if (rb_valid && !rb_ready && fd_ready) stall_bad++;
      if (stall_prev && (!rb_valid || rb_addr != pa || rb_data != pd || rb_be != pb)) hold_bad++;
      stall_prev = rb_valid && !rb_ready;
      pa = rb_addr; pd = rb_data; pb = rb_be;
      if (irq) begin nirq++; if (irq_prev) irq_wide++; end
      irq_prev = irq;
      if (wt_valid && !wt_prev) begin
        wop[nwait[2:0]] = wt_op; wlo[nwait[2:0]] = wt_lo; whi[nwait[2:0]] = wt_hi; nwait++;
      end
      if (wt_valid && (fd_ready || rb_valid)) wait_bad++;
      wt_prev = wt_valid;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    str[slen[8:0]] = w;
    slen++;
  endtask

  task automatic i_wr(input logic [19:0] ofs, input logic [3:0] be, input logic [31:0] d);
    push(d);
    push({8'h01, be, ofs});
  endtask

  task automatic drain(input int limit);
    int g = 0;
    while (sidx < slen && g < limit) begin @(negedge clk); g++; end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 fd_ready", {31'd0, fd_ready}, 32'd1);
    chk("R1 rb_valid", {31'd0, rb_valid}, 32'd0);
    chk("R1 wt_valid", {31'd0, wt_valid}, 32'd0);
    chk("R1 irq",      {31'd0, irq}, 32'd0);
    chk("R1 err",      {31'd0, err}, 32'd0);
  endtask

  task automatic t_single;
    int b0 = nw;
    i_wr(20'h00012, 4'hF, 32'hA5A5A5A5);
    i_wr(20'h00012, 4'b0101, 32'h11223344);
    i_wr(20'h00013, 4'h0, 32'hFFFFFFFF);
    drain(200);
    chk("R2 R3 write count", nw - b0, 3);
    chk("R3 addr", {12'd0, wa[b0]}, 32'h00012);
    chk("R3 data", wd[b0], 32'hA5A5A5A5);
    chk("R3 be", {28'd0, wb[b0+1]}, 32'h5);
    chk("R4 merged bytes", rmod[2], 32'hA522A544);
    chk("R4 zero enables", rmod[3], 32'h0);
  endtask

  task automatic t_idx_odd;
    int b0 = nw;
    push(32'd3); push(32'h09000405);
    push(32'hD0000001); push(32'hD0000002); push(32'hD0000003);
    push(32'h0);
    i_wr(20'h00406, 4'hF, 32'h00000077);
    drain(200);
    chk("R5 odd burst count", nw - b0, 4);
    for (int k = 0; k < 3; k++) begin
      chk("R5 burst addr", {12'd0, wa[b0+k]}, 32'h00405);
      chk("R5 burst data", wd[b0+k], 32'hD0000001 + k);
      chk("R5 burst be", {28'd0, wb[b0+k]}, 32'hF);
    end
    chk("R6 after pad addr", {12'd0, wa[b0+3]}, 32'h00406);
    chk("R6 after pad data", wd[b0+3], 32'h77);
  endtask

  task automatic t_idx_even;
    int b0 = nw;
    push(32'd2); push(32'h09000501);
    push(32'hE1); push(32'hE2);
    push(32'd0); push(32'h09000502);
    i_wr(20'h00503, 4'hF, 32'hE3);
    drain(200);
    chk("R5 even and zero burst count", nw - b0, 3);
    chk("R5 even second data", wd[b0+1], 32'hE2);
    chk("R5 zero burst skipped", {12'd0, wa[b0+2]}, 32'h00503);
  endtask

  task automatic t_backpressure;
    int b0 = nw;
    bp_mode = 1;
    push(32'd4); push(32'h09000600);
    for (int k = 0; k < 4; k++) push(32'hB0 + k);
    i_wr(20'h00601, 4'h3, 32'hCAFE);
    drain(400);
    bp_mode = 0;
    repeat (4) @(negedge clk);
    chk("R7 write count", nw - b0, 5);
    chk("R7 order", wd[b0+3], 32'hB3);
    chk("R7 last data", wd[b0+4], 32'hCAFE);
    chk("R7 no fetch during stall", stall_bad, 0);
    chk("R7 stalled write held", hold_bad, 0);
  endtask

  task automatic t_nop_irq;
    int b0 = nw;
    int i0 = nirq;
    push(32'hDEADBEEF); push(32'h00000000);
    push(32'h0); push(32'h07000000);
    i_wr(20'h00701, 4'hF, 32'h99);
    drain(200);
    chk("R8 nop makes no write", nw - b0, 1);
    chk("R8 following write", {12'd0, wa[b0]}, 32'h00701);
    chk("R9 irq pulses", nirq - i0, 1);
    chk("R9 irq width", irq_wide, 0);
  endtask

  task automatic t_wait;
    int b0 = nw;
    int v0 = nwait;
    push(32'h00001234); push(32'h030ABCDE);
    push(32'h00000055); push(32'h0A000010);
    i_wr(20'h00801, 4'hF, 32'h42);
    drain(300);
    chk("R10 wait count", nwait - v0, 2);
    chk("R10 op", {24'd0, wop[v0]}, 32'h03);
    chk("R10 lo", wlo[v0], 32'h1234);
    chk("R10 hi", {8'd0, whi[v0]}, 32'h0ABCDE);
    chk("R10 poll op", {24'd0, wop[v0+1]}, 32'h0A);
    chk("R10 exclusive", wait_bad, 0);
    chk("R10 resumes", nw - b0, 1);
  endtask

  task automatic t_bad;
    int b0 = nw;
    push(32'h0); push(32'h08000000);
    i_wr(20'h00901, 4'hF, 32'h1);
    drain(30);
    chk("R11 err set", {31'd0, err}, 32'd1);
    chk("R11 no later write", nw - b0, 0);
    chk("R11 fetch stopped", {31'd0, fd_ready}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R11 err sticky", {31'd0, err}, 32'd1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_single;
    t_idx_odd;
    t_idx_even;
    t_backpressure;
    t_nop_irq;
    t_wait;
    t_bad;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run;
  end
endmodule